// File: doc/BRIEF.md
# Post-Update Load Unit

This unit carries out loads whose base register advances after the access. A decoded operation arrives with an access size, an extension choice, an addressing form, two register indices and the operand values. The unit reads memory at the base value exactly as it stood at issue. The loaded bytes are extended to 64 bits and written to the target register. In the same cycle, the base plus an offset is written back to the base register.

The memory side is a request/response port. A request is held until the memory takes it, and a response comes back in a later cycle. Only one access is in flight at a time. The register side uses two write ports that fire together for exactly one cycle.

An encoding the unit cannot carry out is refused within the cycle after issue. For such an encoding the unit raises a one-cycle illegal flag, touches neither memory nor registers, and stays ready. No condition or status state exists or changes.

Top module: `postinc_load_unit`

## Requirements
- R1: The memory request address equals the base value sampled when the operation was accepted, with no offset added. `mem_req_size` carries the size code of the operation.
- R2: The base write-back value is the base value plus an offset, wrapping modulo 2^64. The offset depends on the form code: form 0 (displacement) uses `imm[15:0]` sign-extended; form 1 (indexed) uses `index_val`; form 2 (scaled displacement) uses `imm[13:0]` with two zero bits appended, then sign-extended.
- R3: For the size codes 0, 1 and 2 (1, 2 and 4 bytes) with `op_sign`=0, the target value is the low 1, 2 or 4 response bytes with every higher bit zero. Response bytes above the access size are ignored.
- R4: With `op_sign`=1, a 2-byte load (size code 1) or a 4-byte load (size code 2) sign-extends from its top loaded bit to 64 bits.
- R5: An 8-byte load (size code 3) writes the full 64-bit response word unchanged.
- R6: For each legal operation, `wb_rt_en` and `wb_ra_en` are high together for exactly one cycle. They carry the target and base indices given at issue.
- R7: If the target index equals the base index, or the base index is 0, the operation is illegal.
- R8: The following combinations are also illegal: a sign-extended byte; a sign-extended word in form 0; an 8-byte load in form 0 or with `op_sign`=1; form 2 with any size other than 8 bytes; form code 3.
- R9: An illegal operation raises `illegal` for the one cycle after acceptance. It produces no memory request and no register write, and `op_ready` stays high.
- R10: `op_ready` is high only when the unit is idle. `busy` is high from the cycle after a legal acceptance through the write-back cycle, so at most one access is outstanding.
- R11: While the memory has not taken a request, `mem_req_valid`, `mem_req_addr` and `mem_req_size` stay stable.
- R12: Operand inputs that change after acceptance have no effect on the address or on either written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and able to accept |
| op_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| op_sign | input | 1 | 1 = sign-extend, 0 = zero-extend |
| op_form | input | 2 | Form code: 0 displacement, 1 indexed, 2 scaled displacement |
| op_rt | input | 5 | Target register index |
| op_ra | input | 5 | Base register index |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| imm | input | 16 | Immediate field |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 64 | Access address |
| mem_req_size | output | 2 | Access size code |
| mem_rsp_valid | input | 1 | Response data valid |
| mem_rsp_data | input | 64 | Response data, right-justified, little-endian |
| wb_rt_en | output | 1 | Target register write enable |
| wb_rt_idx | output | 5 | Target register index |
| wb_rt_data | output | 64 | Target register value |
| wb_ra_en | output | 1 | Base register write enable |
| wb_ra_idx | output | 5 | Base register index |
| wb_ra_data | output | 64 | Advanced base value |
| illegal | output | 1 | One-cycle illegal-encoding flag |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the unit with its default parameters: 64-bit data, 5-bit register indices, a 16-bit displacement and a 14-bit scaled field. With these values every size from byte to full word can be tested, including the case where no extension happens at all. Negative displacements and a base value near 2^64 show the sign-extension and wraparound of the base update. Varying the memory stall and response delays exercises request holding and the single-outstanding busy window.

// File: rtl/postinc_load_pkg.sv
package postinc_load_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_DWRD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      FM_DISP   = 2'd0,
      FM_INDEX  = 2'd1,
      FM_SCALED = 2'd2,
      FM_RSVD   = 2'd3
   } addr_form_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2,
      ST_WB   = 2'd3
   } unit_state_e;

endpackage

// File: rtl/pul_legal.sv
module pul_legal #(
   parameter int REG_IDX_W = 5
) (
   input  logic [1:0]           size,
   input  logic                 sign,
   input  logic [1:0]           form,
   input  logic [REG_IDX_W-1:0] rt,
   input  logic [REG_IDX_W-1:0] ra,
   output logic                 legal
);
   import postinc_load_pkg::*;

   logic combo_ok;
   logic regs_ok;
   logic is_disp;
   logic is_index;
   logic is_scaled;

   assign is_disp   = (addr_form_e'(form) == FM_DISP);
   assign is_index  = (addr_form_e'(form) == FM_INDEX);
   assign is_scaled = (addr_form_e'(form) == FM_SCALED);

   always_comb begin
      unique case (acc_size_e'(size))
         SZ_BYTE: combo_ok = !sign && (is_disp || is_index);
         SZ_HALF: combo_ok = is_disp || is_index;
         SZ_WORD: combo_ok = is_index || (is_disp && !sign);
         SZ_DWRD: combo_ok = !sign && (is_scaled || is_index);
         default: combo_ok = 1'b0;
      endcase
   end

   assign regs_ok = (rt != ra) && (ra != '0);
   assign legal   = combo_ok && regs_ok;

endmodule

// File: rtl/pul_offset.sv
module pul_offset #(
   parameter int XLEN = 64,
   parameter int D_W  = 16,
   parameter int DS_W = 14
) (
   input  logic [1:0]      form,
   input  logic [D_W-1:0]  imm,
   input  logic [XLEN-1:0] index,
   output logic [XLEN-1:0] offset
);
   import postinc_load_pkg::*;

   localparam int DSX_W = DS_W + 2;

   logic [XLEN-1:0] disp_off;
   logic [XLEN-1:0] scaled_off;

   assign disp_off   = {{(XLEN-D_W){imm[D_W-1]}}, imm};
   assign scaled_off = {{(XLEN-DSX_W){imm[DS_W-1]}}, imm[DS_W-1:0], 2'b00};

   always_comb begin
      unique case (addr_form_e'(form))
         FM_DISP:   offset = disp_off;
         FM_INDEX:  offset = index;
         FM_SCALED: offset = scaled_off;
         default:   offset = '0;
      endcase
   end

endmodule

// File: rtl/pul_extend.sv
module pul_extend #(
   parameter int XLEN = 64
) (
   input  logic [1:0]      size,
   input  logic            sign,
   input  logic [XLEN-1:0] raw,
   output logic [XLEN-1:0] value
);
   localparam int NSIZES = 4;

   logic [XLEN-1:0] cand [NSIZES];

   for (genvar g = 0; g < NSIZES; g++) begin : g_size
      localparam int BITS = 8 << g;
      if (BITS >= XLEN) begin : g_full
         assign cand[g] = raw;
      end else begin : g_part
         logic fill;
         assign fill    = sign & raw[BITS-1];
         assign cand[g] = {{(XLEN-BITS){fill}}, raw[BITS-1:0]};
      end
   end

   assign value = cand[size];

endmodule

// File: rtl/postinc_load_unit.sv
module postinc_load_unit #(
   parameter int XLEN      = 64,
   parameter int REG_IDX_W = 5,
   parameter int D_W       = 16,
   parameter int DS_W      = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   output logic                 op_ready,
   input  logic [1:0]           op_size,
   input  logic                 op_sign,
   input  logic [1:0]           op_form,
   input  logic [REG_IDX_W-1:0] op_rt,
   input  logic [REG_IDX_W-1:0] op_ra,
   input  logic [XLEN-1:0]      base_val,
   input  logic [XLEN-1:0]      index_val,
   input  logic [D_W-1:0]       imm,
   output logic                 mem_req_valid,
   input  logic                 mem_req_ready,
   output logic [XLEN-1:0]      mem_req_addr,
   output logic [1:0]           mem_req_size,
   input  logic                 mem_rsp_valid,
   input  logic [XLEN-1:0]      mem_rsp_data,
   output logic                 wb_rt_en,
   output logic [REG_IDX_W-1:0] wb_rt_idx,
   output logic [XLEN-1:0]      wb_rt_data,
   output logic                 wb_ra_en,
   output logic [REG_IDX_W-1:0] wb_ra_idx,
   output logic [XLEN-1:0]      wb_ra_data,
   output logic                 illegal,
   output logic                 busy
);
   import postinc_load_pkg::*;

   if (XLEN != 64) begin : g_bad_xlen
      $error("postinc_load_unit: XLEN must be 64 to hold an 8-byte access");
   end
   if (DS_W + 2 > D_W) begin : g_bad_ds
      $error("postinc_load_unit: scaled field plus two bits must fit the immediate");
   end
   if (D_W > XLEN) begin : g_bad_d
      $error("postinc_load_unit: immediate wider than data path");
   end
   if (REG_IDX_W < 1) begin : g_bad_idx
      $error("postinc_load_unit: register index width must be positive");
   end

   unit_state_e          state_q;
   logic                 accept;
   logic                 op_legal;
   logic [XLEN-1:0]      off_now;
   logic [XLEN-1:0]      ext_now;
   logic [XLEN-1:0]      base_q;
   logic [XLEN-1:0]      off_q;
   logic [XLEN-1:0]      data_q;
   logic [1:0]           size_q;
   logic                 sign_q;
   logic [REG_IDX_W-1:0] rt_q;
   logic [REG_IDX_W-1:0] ra_q;
   logic                 illegal_q;

   pul_legal #(
      .REG_IDX_W(REG_IDX_W)
   ) u_legal (
      .size (op_size),
      .sign (op_sign),
      .form (op_form),
      .rt   (op_rt),
      .ra   (op_ra),
      .legal(op_legal)
   );

   pul_offset #(
      .XLEN(XLEN),
      .D_W (D_W),
      .DS_W(DS_W)
   ) u_offset (
      .form  (op_form),
      .imm   (imm),
      .index (index_val),
      .offset(off_now)
   );

   pul_extend #(
      .XLEN(XLEN)
   ) u_extend (
      .size (size_q),
      .sign (sign_q),
      .raw  (mem_rsp_data),
      .value(ext_now)
   );

   assign op_ready = (state_q == ST_IDLE);
   assign accept   = op_valid && op_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         base_q    <= '0;
         off_q     <= '0;
         data_q    <= '0;
         size_q    <= '0;
         sign_q    <= 1'b0;
         rt_q      <= '0;
         ra_q      <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= accept && !op_legal;
         unique case (state_q)
            ST_IDLE: begin
               if (accept && op_legal) begin
                  base_q  <= base_val;
                  off_q   <= off_now;
                  size_q  <= op_size;
                  sign_q  <= op_sign;
                  rt_q    <= op_rt;
                  ra_q    <= op_ra;
                  state_q <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready) begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  data_q  <= ext_now;
                  state_q <= ST_WB;
               end
            end
            ST_WB: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == ST_REQ);
   assign mem_req_addr  = base_q;
   assign mem_req_size  = size_q;

   assign wb_rt_en   = (state_q == ST_WB);
   assign wb_rt_idx  = rt_q;
   assign wb_rt_data = data_q;
   assign wb_ra_en   = (state_q == ST_WB);
   assign wb_ra_idx  = ra_q;
   assign wb_ra_data = base_q + off_q;

   assign illegal = illegal_q;
   assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/postinc_load_unit_chk.sv
module postinc_load_unit_chk #(
   parameter int XLEN      = 64,
   parameter int REG_IDX_W = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic                 op_ready,
   input logic [1:0]           op_form,
   input logic [XLEN-1:0]      base_val,
   input logic [XLEN-1:0]      index_val,
   input logic                 mem_req_valid,
   input logic                 mem_req_ready,
   input logic [XLEN-1:0]      mem_req_addr,
   input logic [1:0]           mem_req_size,
   input logic                 wb_rt_en,
   input logic [REG_IDX_W-1:0] wb_rt_idx,
   input logic                 wb_ra_en,
   input logic [REG_IDX_W-1:0] wb_ra_idx,
   input logic [XLEN-1:0]      wb_ra_data,
   input logic                 illegal,
   input logic                 busy
);
   logic [XLEN-1:0] sh_base;
   logic [XLEN-1:0] sh_index;
   logic            sh_indexed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_base    <= '0;
         sh_index   <= '0;
         sh_indexed <= 1'b0;
      end else if (op_valid && op_ready) begin
         sh_base    <= base_val;
         sh_index   <= index_val;
         sh_indexed <= (op_form == 2'd1);
      end
   end

   AST_REQ_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> mem_req_addr == sh_base); // R1

   AST_INDEXED_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_ra_en && sh_indexed) |-> wb_ra_data == sh_base + sh_index); // R2

   AST_WB_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      wb_rt_en == wb_ra_en); // R6

   AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_rt_en |=> !wb_rt_en); // R6

   AST_WB_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      wb_ra_en |-> (wb_ra_idx != wb_rt_idx) && (wb_ra_idx != '0)); // R7

   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !mem_req_valid && !wb_rt_en && !busy && op_ready); // R9

   AST_ILLEGAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> !illegal || $past(op_valid)); // R9

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !op_ready); // R10

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_size)); // R11

endmodule

bind postinc_load_unit postinc_load_unit_chk #(
   .XLEN     (XLEN),
   .REG_IDX_W(REG_IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_valid     (op_valid),
   .op_ready     (op_ready),
   .op_form      (op_form),
   .base_val     (base_val),
   .index_val    (index_val),
   .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready),
   .mem_req_addr (mem_req_addr),
   .mem_req_size (mem_req_size),
   .wb_rt_en     (wb_rt_en),
   .wb_rt_idx    (wb_rt_idx),
   .wb_ra_en     (wb_ra_en),
   .wb_ra_idx    (wb_ra_idx),
   .wb_ra_data   (wb_ra_data),
   .illegal      (illegal),
   .busy         (busy)
);

// File: tb/postinc_load_unit_test.sv
module postinc_load_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [1:0]  op_size = '0;
   logic        op_sign = 1'b0;
   logic [1:0]  op_form = '0;
   logic [4:0]  op_rt = '0;
   logic [4:0]  op_ra = '0;
   logic [63:0] base_val = '0;
   logic [63:0] index_val = '0;
   logic [15:0] imm = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [63:0] mem_req_addr;
   logic [1:0]  mem_req_size;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        wb_rt_en;
   logic [4:0]  wb_rt_idx;
   logic [63:0] wb_rt_data;
   logic        wb_ra_en;
   logic [4:0]  wb_ra_idx;
   logic [63:0] wb_ra_data;
   logic        illegal;
   logic        busy;

   int          checks = 0;
   int          errors = 0;
   logic [63:0] exp_addr = '0;
   logic [1:0]  exp_size = '0;
   logic [63:0] next_rsp = '0;
   int          req_count = 0;

   always #5 clk = ~clk;

   postinc_load_unit uut (
      .clk(clk), .rst_n(rst_n),
      .op_valid(op_valid), .op_ready(op_ready),
      .op_size(op_size), .op_sign(op_sign), .op_form(op_form),
      .op_rt(op_rt), .op_ra(op_ra),
      .base_val(base_val), .index_val(index_val), .imm(imm),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .wb_rt_en(wb_rt_en), .wb_rt_idx(wb_rt_idx), .wb_rt_data(wb_rt_data),
      .wb_ra_en(wb_ra_en), .wb_ra_idx(wb_ra_idx), .wb_ra_data(wb_ra_data),
      .illegal(illegal), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_value(input logic [1:0] sz, input logic sg,
                                            input logic [63:0] rsp);
      case (sz)
         2'd0: return {56'd0, rsp[7:0]};
         2'd1: return sg ? {{48{rsp[15]}}, rsp[15:0]} : {48'd0, rsp[15:0]};
         2'd2: return sg ? {{32{rsp[31]}}, rsp[31:0]} : {32'd0, rsp[31:0]};
         default: return rsp;
      endcase
   endfunction

   function automatic logic [63:0] ref_offset(input logic [1:0] fm, input logic [15:0] im,
                                             input logic [63:0] ix);
      case (fm)
         2'd0: return {{48{im[15]}}, im};
         2'd1: return ix;
         default: return {{48{im[13]}}, im[13:0], 2'b00};
      endcase
   endfunction

   // memory model: random stall before taking a request, random delay to response
   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rst_n && mem_req_valid) begin
            logic [63:0] a0;
            a0 = mem_req_addr;
            req_count++;
            chk(mem_req_addr == exp_addr, "R1 address", mem_req_addr, exp_addr);
            chk(mem_req_size == exp_size, "R1 size", {62'd0, mem_req_size}, {62'd0, exp_size});
            repeat ($urandom % 3) begin
               @(negedge clk);
               chk(mem_req_valid && mem_req_addr == a0, "R11 hold", mem_req_addr, a0);
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat ($urandom % 3) @(negedge clk);
            mem_rsp_data  = next_rsp;
            mem_rsp_valid = 1'b1;
         end
      end
   end

   task automatic run_op(input logic [1:0] sz, input logic sg, input logic [1:0] fm,
                         input logic [4:0] rt, input logic [4:0] ra,
                         input logic [63:0] base, input logic [63:0] ix,
                         input logic [15:0] im, input logic [63:0] rsp,
                         input bit legal, input string tag);
      logic [63:0] ev;
      logic [63:0] eb;
      int          n;
      int          reqs0;
      @(negedge clk);
      chk(op_ready && !busy, "R10 idle before issue", {62'd0, op_ready, busy}, 64'd2);
      op_size = sz; op_sign = sg; op_form = fm; op_rt = rt; op_ra = ra;
      base_val = base; index_val = ix; imm = im;
      next_rsp = rsp; exp_addr = base; exp_size = sz;
      ev = ref_value(sz, sg, rsp);
      eb = base + ref_offset(fm, im, ix);
      reqs0 = req_count;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      // disturb operands after acceptance
      base_val  = {$urandom, $urandom};
      index_val = {$urandom, $urandom};
      imm       = 16'($urandom);
      op_rt     = 5'($urandom);
      op_ra     = 5'($urandom);
      if (!legal) begin
         chk(illegal && !mem_req_valid && !wb_rt_en && !wb_ra_en && op_ready,
             {tag, " illegal flag"}, {59'd0, illegal, mem_req_valid, wb_rt_en, wb_ra_en, op_ready},
             64'h11);
         @(negedge clk);
         chk(!illegal && !wb_rt_en && req_count == reqs0, {tag, " illegal quiet"},
             {63'd0, illegal}, 64'd0);
      end else begin
         chk(!illegal && busy && !op_ready, "R10 busy after accept",
             {62'd0, busy, op_ready}, 64'd2);
         n = 0;
         while (!wb_rt_en && n < 40) begin
            if (!busy || op_ready) chk(0, "R10 busy window", {62'd0, busy, op_ready}, 64'd2);
            @(negedge clk);
            n++;
         end
         chk(wb_rt_en && wb_ra_en, "R6 both enables", {62'd0, wb_rt_en, wb_ra_en}, 64'd3);
         chk(wb_rt_idx == rt && wb_ra_idx == ra, "R6 indices",
             {54'd0, wb_rt_idx, wb_ra_idx}, {54'd0, rt, ra});
         chk(wb_rt_data == ev, tag, wb_rt_data, ev);
         chk(wb_ra_data == eb, "R2/R12 base update", wb_ra_data, eb);
         @(negedge clk);
         chk(!wb_rt_en && !wb_ra_en && !busy && op_ready, "R6/R10 single write",
             {61'd0, wb_rt_en, wb_ra_en, busy}, 64'd0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234567));
      repeat (3) @(negedge clk);
      chk(!busy && !illegal && !mem_req_valid && !wb_rt_en && !wb_ra_en, "R10 reset state",
          {60'd0, busy, illegal, mem_req_valid, wb_rt_en}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(op_ready, "R10 ready after reset", {63'd0, op_ready}, 64'd1);

      // directed: extension with junk above the access (R3, R4, R5)
      run_op(2'd0, 0, 2'd0, 5'd3, 5'd4, 64'h1000, 64'd0, 16'd1, 64'hFFFF_FFFF_FFFF_FF80, 1, "R3 byte zero");
      run_op(2'd1, 0, 2'd1, 5'd3, 5'd4, 64'h2000, 64'd8, 16'd0, 64'hDEAD_BEEF_1234_8001, 1, "R3 half zero");
      run_op(2'd2, 0, 2'd0, 5'd3, 5'd4, 64'h3000, 64'd0, 16'h0004, 64'hAAAA_AAAA_8765_4321, 1, "R3 word zero");
      run_op(2'd1, 1, 2'd0, 5'd7, 5'd9, 64'h4000, 64'd0, 16'h8000, 64'h0000_0000_0000_8001, 1, "R4 half sign neg");
      run_op(2'd1, 1, 2'd1, 5'd7, 5'd9, 64'h4000, 64'd2, 16'h0, 64'hFFFF_FFFF_FFFF_7FFF, 1, "R4 half sign pos");
      run_op(2'd2, 1, 2'd1, 5'd7, 5'd9, 64'h5000, 64'hFFFF_FFFF_FFFF_FFFC, 16'h0, 64'h0000_0001_8000_0000, 1, "R4 word sign");
      run_op(2'd3, 0, 2'd2, 5'd1, 5'd2, 64'h6000, 64'd0, 16'h3FFF, 64'h8123_4567_89AB_CDEF, 1, "R5 dword scaled neg");
      run_op(2'd3, 0, 2'd2, 5'd1, 5'd2, 64'h6000, 64'd0, 16'hC001, 64'h0123_4567_89AB_CDEF, 1, "R5 dword scaled pos");
      run_op(2'd3, 0, 2'd1, 5'd1, 5'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 16'h0, 64'hFEDC_BA98_7654_3210, 1, "R5 dword wrap R2");

      // directed: illegal encodings (R7, R8, R9)
      run_op(2'd0, 0, 2'd0, 5'd5, 5'd5, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R7 rt equals ra");
      run_op(2'd1, 0, 2'd1, 5'd5, 5'd0, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R7 ra zero");
      run_op(2'd2, 1, 2'd0, 5'd5, 5'd6, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R8 word sign disp");
      run_op(2'd0, 1, 2'd1, 5'd5, 5'd6, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R8 byte sign");
      run_op(2'd2, 0, 2'd2, 5'd5, 5'd6, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R8 scaled non-dword");
      run_op(2'd3, 0, 2'd0, 5'd5, 5'd6, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R8 dword disp");
      run_op(2'd3, 1, 2'd1, 5'd5, 5'd6, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R8 dword sign");
      run_op(2'd1, 0, 2'd3, 5'd5, 5'd6, 64'h100, 64'd0, 16'd1, 64'd0, 0, "R8 reserved form");

      // random legal operations
      for (int i = 0; i < 300; i++) begin
         logic [1:0] sz;
         logic       sg;
         logic [1:0] fm;
         logic [4:0] ra;
         logic [4:0] rt;
         case ($urandom % 11)
            0: begin sz = 0; sg = 0; fm = 0; end
            1: begin sz = 0; sg = 0; fm = 1; end
            2: begin sz = 1; sg = 0; fm = 0; end
            3: begin sz = 1; sg = 0; fm = 1; end
            4: begin sz = 1; sg = 1; fm = 0; end
            5: begin sz = 1; sg = 1; fm = 1; end
            6: begin sz = 2; sg = 0; fm = 0; end
            7: begin sz = 2; sg = 0; fm = 1; end
            8: begin sz = 2; sg = 1; fm = 1; end
            9: begin sz = 3; sg = 0; fm = 2; end
            default: begin sz = 3; sg = 0; fm = 1; end
         endcase
         ra = 5'(1 + ($urandom % 31));
         rt = 5'(ra + 1 + ($urandom % 31));
         run_op(sz, sg, fm, rt, ra, {$urandom, $urandom}, {$urandom, $urandom},
                16'($urandom), {$urandom, $urandom}, 1, "R3/R4/R5 random value");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule